// File: doc/BRIEF.md
# Mode-Selectable Multiphase Clock Divider

This block derives two slower clocks from a single master clock. A one-bit mode input chooses how the master clock is divided to make the sample clock. In real-sample mode the division is by seven, with the sample clock high for four master cycles and low for three. In complex-sample mode the division is by six, with three cycles high and three low. With a nominal 40 MHz master in real-sample mode, the sample clock runs near 5.714 MHz. A complex-sample system would normally supply a 35 MHz master instead.

Alongside the sample clock the block produces a clock at exactly half the master rate, high for one master cycle and low for the next. It also produces a one-master-cycle enable, so that downstream logic in the master domain can act on each sample-clock rising edge without needing a second clock.

A change of mode is held off until the current sample period ends. A period is therefore never cut short or stretched, and no runt pulse appears. Every output comes straight from a flip-flop.

Top module: `cdiv_clkgen`

## Requirements
- R1: With mode_i = 0 (real-sample), every sample period lasts 7 master cycles, measured from one samp_stb_o pulse to the next.
- R2: With mode_i = 1 (complex-sample), every sample period lasts 6 master cycles.
- R3: In a period divided by 7, samp_clk_o is high for the first 4 master cycles and low for the last 3.
- R4: In a period divided by 6, samp_clk_o is high for the first 3 master cycles and low for the last 3.
- R5: half_clk_o changes level on every master clock edge, giving half the master frequency with equal high and low times.
- R6: samp_stb_o is high for exactly one master cycle, in the cycle where samp_clk_o has just gone from low to high, and is low in every other cycle.
- R7: The value of mode_i only takes effect at the edge where a period ends. A period that is already running keeps its length, even if mode_i changes part way through it.
- R8: While rst_ni is low, samp_clk_o is 1, half_clk_o is 0 and samp_stb_o is 0. The first period after reset always divides by 7, whatever the value of mode_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mode_i | input | 1 | Division select: 0 means divide by 7, 1 means divide by 6 |
| samp_clk_o | output | 1 | Registered sample clock with an asymmetric duty cycle |
| half_clk_o | output | 1 | Registered half-rate clock with a 1:1 duty cycle |
| samp_stb_o | output | 1 | One-cycle strobe marking each rising edge of the sample clock |

## Verification
A table of mode values is applied with the switches made at period boundaries. This covers repeated complex periods, a return to real mode, and alternation in both directions. Each switch first checks that the period in progress keeps its old length and then that the next period has the new length and duty split, so a divider that picks up the mode early shows up apart from one that uses the wrong split.

A mode flip in the middle of a period separates sampling at the wrap from sampling on every cycle. Reset is held with complex mode selected, which exposes a divider that ignores the fixed first period. The half-rate clock is traced on every cycle to check that it toggles on each edge. The strobe is compared on every cycle against the sample clock's rising edges.

// File: rtl/cdiv_pkg.sv
package cdiv_pkg;

   typedef enum logic {
      CDIV_REAL = 1'b0,
      CDIV_CPLX = 1'b1
   } cdiv_mode_e;

   function automatic int cdiv_max(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/cdiv_ratio_sel.sv
module cdiv_ratio_sel
   import cdiv_pkg::*;
#(
   parameter int CNT_W     = 3,
   parameter int DIV_REAL  = 7,
   parameter int HIGH_REAL = 4,
   parameter int DIV_CPLX  = 6,
   parameter int HIGH_CPLX = 3,
   parameter bit RST_MODE  = 1'b0
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             mode_i,
   input  logic             wrap_i,
   output logic [CNT_W-1:0] last_o,
   output logic [CNT_W-1:0] high_cur_o,
   output logic [CNT_W-1:0] high_nxt_o
);

   localparam logic [CNT_W-1:0] LastReal = CNT_W'(DIV_REAL - 1);
   localparam logic [CNT_W-1:0] LastCplx = CNT_W'(DIV_CPLX - 1);
   localparam logic [CNT_W-1:0] HiReal   = CNT_W'(HIGH_REAL);
   localparam logic [CNT_W-1:0] HiCplx   = CNT_W'(HIGH_CPLX);

   cdiv_mode_e sel_q;
   cdiv_mode_e sel_nxt;

   // The mode input is only looked at on the wrap cycle.
   always_comb begin
      sel_nxt = sel_q;
      if (wrap_i) begin
         sel_nxt = cdiv_mode_e'(mode_i);
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         sel_q <= cdiv_mode_e'(RST_MODE);
      end else begin
         sel_q <= sel_nxt;
      end
   end

   always_comb begin
      last_o     = (sel_q == CDIV_CPLX) ? LastCplx : LastReal;
      high_cur_o = (sel_q == CDIV_CPLX) ? HiCplx : HiReal;
      high_nxt_o = (sel_nxt == CDIV_CPLX) ? HiCplx : HiReal;
   end

   // R7: the active ratio only moves after a wrap edge
   a_r7_switch_at_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !$stable(sel_q) |-> $past(wrap_i));

endmodule

// File: rtl/cdiv_counter.sv
module cdiv_counter #(
   parameter int CNT_W = 3
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [CNT_W-1:0] last_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic [CNT_W-1:0] cnt_nxt_o,
   output logic             wrap_o
);

   logic [CNT_W-1:0] cnt_q;

   always_comb begin
      wrap_o    = (cnt_q == last_i);
      cnt_nxt_o = wrap_o ? '0 : cnt_q + 1'b1;
      cnt_o     = cnt_q;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_nxt_o;
      end
   end

   // R1, R2: the phase never passes the last step of the active ratio
   a_r1_r2_cnt_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cnt_q <= last_i);

endmodule

// File: rtl/cdiv_wave.sv
module cdiv_wave #(
   parameter int CNT_W     = 3,
   parameter int HIGH_REAL = 4,
   parameter int HIGH_CPLX = 3
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [CNT_W-1:0] cnt_i,
   input  logic [CNT_W-1:0] cnt_nxt_i,
   input  logic [CNT_W-1:0] high_cur_i,
   input  logic [CNT_W-1:0] high_nxt_i,
   output logic             samp_clk_o,
   output logic             samp_stb_o
);

   logic samp_d;
   logic stb_d;

   generate
      if (HIGH_REAL == HIGH_CPLX) begin : g_fixed_high
         localparam logic [CNT_W-1:0] HiConst = CNT_W'(HIGH_REAL);
         always_comb samp_d = (cnt_nxt_i < HiConst);
      end else begin : g_mux_high
         always_comb samp_d = (cnt_nxt_i < high_nxt_i);
      end
   endgenerate

   always_comb stb_d = (cnt_nxt_i == '0);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         samp_clk_o <= 1'b1;
         samp_stb_o <= 1'b0;
      end else begin
         samp_clk_o <= samp_d;
         samp_stb_o <= stb_d;
      end
   end

   // R6: a rising sample clock always comes with the strobe
   a_r6_rise_has_stb: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(samp_clk_o) |-> samp_stb_o);
   // R6: the strobe never appears without a rising sample clock
   a_r6_stb_only_on_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
      samp_stb_o |-> $rose(samp_clk_o));
   // R3, R4: the falling edge lands on the phase given by the active split
   a_r3_r4_fall_phase: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(samp_clk_o) |-> (cnt_i == high_cur_i));

endmodule

// File: rtl/cdiv_half.sv
module cdiv_half (
   input  logic clk_i,
   input  logic rst_ni,
   output logic half_clk_o
);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         half_clk_o <= 1'b0;
      end else begin
         half_clk_o <= ~half_clk_o;
      end
   end

   // R5: the level changes on every master edge
   a_r5_half_toggles: assert property (@(posedge clk_i) disable iff (!rst_ni)
      1'b1 |=> (half_clk_o != $past(half_clk_o)));

endmodule

// File: rtl/cdiv_clkgen.sv
module cdiv_clkgen
   import cdiv_pkg::*;
#(
   parameter int DIV_REAL  = 7,
   parameter int HIGH_REAL = 4,
   parameter int DIV_CPLX  = 6,
   parameter int HIGH_CPLX = 3,
   parameter bit RST_MODE  = 1'b0
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic mode_i,
   output logic samp_clk_o,
   output logic half_clk_o,
   output logic samp_stb_o
);

   localparam int DivMax = cdiv_max(DIV_REAL, DIV_CPLX);
   localparam int CntW   = $clog2(DivMax);

   generate
      if (DIV_REAL < 2 || DIV_CPLX < 2) begin : g_bad_div
         $error("cdiv_clkgen: both ratios must be at least 2");
      end
      if (HIGH_REAL < 1 || HIGH_REAL >= DIV_REAL) begin : g_bad_high_real
         $error("cdiv_clkgen: HIGH_REAL must lie in 1..DIV_REAL-1");
      end
      if (HIGH_CPLX < 1 || HIGH_CPLX >= DIV_CPLX) begin : g_bad_high_cplx
         $error("cdiv_clkgen: HIGH_CPLX must lie in 1..DIV_CPLX-1");
      end
   endgenerate

   logic [CntW-1:0] last;
   logic [CntW-1:0] high_cur;
   logic [CntW-1:0] high_nxt;
   logic [CntW-1:0] cnt;
   logic [CntW-1:0] cnt_nxt;
   logic            wrap;

   cdiv_ratio_sel #(
      .CNT_W    (CntW),
      .DIV_REAL (DIV_REAL),
      .HIGH_REAL(HIGH_REAL),
      .DIV_CPLX (DIV_CPLX),
      .HIGH_CPLX(HIGH_CPLX),
      .RST_MODE (RST_MODE)
   ) u_ratio (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .mode_i    (mode_i),
      .wrap_i    (wrap),
      .last_o    (last),
      .high_cur_o(high_cur),
      .high_nxt_o(high_nxt)
   );

   cdiv_counter #(
      .CNT_W(CntW)
   ) u_cnt (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .last_i   (last),
      .cnt_o    (cnt),
      .cnt_nxt_o(cnt_nxt),
      .wrap_o   (wrap)
   );

   cdiv_wave #(
      .CNT_W    (CntW),
      .HIGH_REAL(HIGH_REAL),
      .HIGH_CPLX(HIGH_CPLX)
   ) u_wave (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .cnt_i     (cnt),
      .cnt_nxt_i (cnt_nxt),
      .high_cur_i(high_cur),
      .high_nxt_i(high_nxt),
      .samp_clk_o(samp_clk_o),
      .samp_stb_o(samp_stb_o)
   );

   cdiv_half u_half (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .half_clk_o(half_clk_o)
   );

endmodule

// File: tb/cdiv_clkgen_tb.sv
module cdiv_clkgen_tb;

   logic clk   = 1'b0;
   logic rst_n = 1'b0;
   logic mode  = 1'b1;
   logic samp_clk;
   logic half_clk;
   logic samp_stb;

   int checks = 0;
   int errors = 0;

   always #5 clk = ~clk;

   cdiv_clkgen u_dut (
      .clk_i     (clk),
      .rst_ni    (rst_n),
      .mode_i    (mode),
      .samp_clk_o(samp_clk),
      .half_clk_o(half_clk),
      .samp_stb_o(samp_stb)
   );

   localparam int VN = 6;
   localparam bit VMODE [VN] = '{1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0};
   localparam int VDIV  [VN] = '{6, 6, 7, 6, 7, 7};
   localparam int VHIGH [VN] = '{3, 3, 4, 3, 4, 4};

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual %0d expected %0d", req, act, exp);
      end
   endtask

   // Call on a negedge that carries the strobe. Measures one period and
   // ends on the negedge of the next strobe.
   task automatic measure(output int len, output int hi, output int bad_half,
                          output int bad_stb);
      logic ph;
      logic ps;
      len = 0; hi = 0; bad_half = 0; bad_stb = 0;
      ph = half_clk;
      ps = samp_clk;
      do begin
         if (samp_clk) hi++;
         len++;
         @(negedge clk);
         if (half_clk == ph) bad_half++;
         if (samp_stb != (samp_clk && !ps)) bad_stb++;
         ph = half_clk;
         ps = samp_clk;
      end while (!samp_stb);
   endtask

   initial begin
      int len, hi, bh, bs, prev_div, n;

      // R8: state held while in reset
      repeat (3) @(negedge clk);
      check(samp_clk == 1'b1, "R8 samp_clk in reset", samp_clk, 1);
      check(half_clk == 1'b0, "R8 half_clk in reset", half_clk, 0);
      check(samp_stb == 1'b0, "R8 samp_stb in reset", samp_stb, 0);

      // R8: first period divides by 7 even though mode selects 6
      rst_n = 1'b1;
      n = 0; hi = 0;
      do begin
         if (samp_clk) hi++;
         n++;
         @(negedge clk);
      end while (!samp_stb);
      check(n == 7, "R8 first period length", n, 7);
      check(hi == 4, "R3 first period high time", hi, 4);

      // Table walk: mode changes at each strobe
      prev_div = 6;
      for (int i = 0; i < VN; i++) begin
         mode = VMODE[i];
         measure(len, hi, bh, bs);
         check(len == prev_div, "R7 period in progress keeps length", len, prev_div);
         measure(len, hi, bh, bs);
         check(len == VDIV[i], VMODE[i] ? "R2 period length" : "R1 period length",
               len, VDIV[i]);
         check(hi == VHIGH[i], VMODE[i] ? "R4 high time" : "R3 high time",
               hi, VHIGH[i]);
         check(bh == 0, "R5 half clock toggles every cycle", bh, 0);
         check(bs == 0, "R6 strobe matches sample rise", bs, 0);
         prev_div = VDIV[i];
      end

      // R7: flip mode to complex in the middle of a divide-by-7 period
      n = 0;
      do begin
         if (n == 3) mode = 1'b1;
         n++;
         @(negedge clk);
      end while (!samp_stb);
      check(n == 7, "R7 mid-period switch to 6", n, 7);
      measure(len, hi, bh, bs);
      check(len == 6, "R2 period after mid switch", len, 6);
      check(hi == 3, "R4 high time after mid switch", hi, 3);

      // R7: flip mode to real in the middle of a divide-by-6 period
      n = 0;
      do begin
         if (n == 2) mode = 1'b0;
         n++;
         @(negedge clk);
      end while (!samp_stb);
      check(n == 6, "R7 mid-period switch to 7", n, 6);
      measure(len, hi, bh, bs);
      check(len == 7, "R1 period after mid switch", len, 7);
      check(bs == 0, "R6 strobe after mid switch", bs, 0);

      // R8: reset in mid period returns outputs to the reset state
      repeat (2) @(negedge clk);
      rst_n = 1'b0;
      #1;
      check(samp_clk == 1'b1, "R8 samp_clk after second reset", samp_clk, 1);
      check(half_clk == 1'b0, "R8 half_clk after second reset", half_clk, 0);
      check(samp_stb == 1'b0, "R8 samp_stb after second reset", samp_stb, 0);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog actual %0d expected %0d", 20000, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule